// File: doc/BRIEF.md
# Speculative Switch Allocator

This block decides, every cycle, which router input may drive which output port through the crossbar. It serves two kinds of requester at once. Flits that already own a downstream virtual channel ask normally. Head flits that are still competing for a virtual channel in the same cycle may ask speculatively. Switch arbitration only needs the target physical output and not the virtual channel, so the two allocations can run side by side.

Allocation is separable and input-first. Each input first reduces its request vector to a single output, the lowest-numbered one it asks for. Each output then chooses one input among those that picked it. Non-speculative requesters are served ahead of speculative ones. Within each class, a round-robin pointer kept per output breaks ties.

A speculative win only counts if the virtual-channel allocation for that input succeeded in the same cycle. If it did not, the grant is still reported but marked unused, and the output stays idle for that cycle. The pointer does not move, and the flit must ask again on a later cycle. A per-cycle count of such wasted grants is provided. All outputs are registered: they describe the decision for the inputs sampled at the previous rising edge.

Top module: `spec_sw_alloc`

## Requirements
- R1: After synchronous reset, `gnt_o`, `used_o` and `waste_cnt_o` are all zero, and every round-robin pointer (both classes, every output) points at input 0.
- R2: Input i's request vector is bits `req_i[i*N +: N]`, where bit o asks for output o. Input i is granted at most one output, and only the lowest-numbered output it requested.
- R3: Each output is granted to at most one input per cycle. Its grant appears as bit `gnt_o[i*N + o]`.
- R4: If any non-speculative input (`spec_i[i]`=0) picked output o, no speculative input is granted o in that cycle.
- R5: Within the winning class of an output, the winner is the first requester at or after that class's pointer, searching upward with wrap-around. After a used grant, that pointer moves to winner+1 modulo N.
- R6: A speculative grant whose `va_ok_i` bit is 0 still shows in `gnt_o` but has `used_o` low. The speculative pointer of that output does not move, so the same input wins again under the same requests.
- R7: `waste_cnt_o` equals the number of inputs that won a speculative grant with `va_ok_i` low in the decided cycle.
- R8: Outputs change only at a rising clock edge, and they reflect the inputs present at that edge.
- R9: `va_ok_i` has no effect on non-speculative requests: a non-speculative grant always has `used_o` high.
- R10: An input with an all-zero request vector receives no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N*N | Per-input output request vectors, input i at bits [i*N +: N] |
| spec_i | input | N | Per-input flag: request is speculative |
| va_ok_i | input | N | Per-input flag: parallel VC allocation succeeded this cycle |
| gnt_o | output | N*N | Registered grant matrix, input i's one-hot output at [i*N +: N] |
| used_o | output | N | Registered per-input flag: grant will be used |
| waste_cnt_o | output | $clog2(N+1) | Registered count of wasted speculative grants |

## Verification
Directed patterns come first. One input asks for several outputs, which checks the input-side choice. All inputs then ask for the same output, which exposes pointer rotation. Mixed-class contention separates priority from rotation. A repeated speculative failure shows that the pointer stays put after a waste. A non-speculative request with the VC flag low shows that the flag is ignored for that class. After that, a long pseudo-random sweep over the 4-port configuration drives mixed request densities, class flags and VC outcomes. A running bench model of all eight pointers predicts every grant, use flag and waste count. A stale or wrongly advanced pointer therefore shows up as a later miscompare, not only in the cycle where the mistake happens.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
  typedef enum logic [1:0] {
    CLS_IDLE = 2'd0,
    CLS_NS   = 2'd1,
    CLS_SP   = 2'd2
  } ssa_cls_e;
endpackage

// File: rtl/ssa_rr_arb.sv
module ssa_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          valid
);
  always_comb begin
    gnt   = '0;
    idx   = '0;
    valid = 1'b0;
    for (int k = 0; k < N; k++) begin
      int c;
      c = (int'(ptr) + k) % N;
      if (!valid && req[c]) begin
        valid  = 1'b1;
        gnt[c] = 1'b1;
        idx    = IW'(c);
      end
    end
  end
endmodule

// File: rtl/ssa_in_pick.sv
module ssa_in_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] pick
);
  always_comb begin
    pick = '0;
    for (int o = 0; o < N; o++) begin
      if (req[o] && (pick == '0)) pick[o] = 1'b1;
    end
  end
endmodule

// File: rtl/ssa_out_stage.sv
module ssa_out_stage
  import ssa_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ns_req,
  input  logic [N-1:0] sp_req,
  input  logic [N-1:0] va_ok,
  output logic [N-1:0] win
);
  logic [IW-1:0] ns_ptr, sp_ptr, ns_idx, sp_idx;
  logic [N-1:0]  ns_gnt, sp_gnt;
  logic          ns_v, sp_v, fire;
  ssa_cls_e      cls;

  ssa_rr_arb #(.N(N)) u_ns (.req(ns_req), .ptr(ns_ptr), .gnt(ns_gnt), .idx(ns_idx), .valid(ns_v));
  ssa_rr_arb #(.N(N)) u_sp (.req(sp_req), .ptr(sp_ptr), .gnt(sp_gnt), .idx(sp_idx), .valid(sp_v));

  always_comb begin
    if (ns_v)      cls = CLS_NS;
    else if (sp_v) cls = CLS_SP;
    else           cls = CLS_IDLE;
    case (cls)
      CLS_NS:  win = ns_gnt;
      CLS_SP:  win = sp_gnt;
      default: win = '0;
    endcase
    fire = (cls == CLS_SP) && va_ok[sp_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_ptr <= '0;
      sp_ptr <= '0;
    end else if (cls == CLS_NS) begin
      ns_ptr <= (ns_idx == IW'(N-1)) ? '0 : ns_idx + 1'b1;
    end else if (fire) begin
      sp_ptr <= (sp_idx == IW'(N-1)) ? '0 : sp_idx + 1'b1;
    end
  end
endmodule

// File: rtl/spec_sw_alloc.sv
module spec_sw_alloc #(
  parameter int N = 4,
  localparam int CW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N*N-1:0] req_i,
  input  logic [N-1:0]   spec_i,
  input  logic [N-1:0]   va_ok_i,
  output logic [N*N-1:0] gnt_o,
  output logic [N-1:0]   used_o,
  output logic [CW-1:0]  waste_cnt_o
);
  logic [N-1:0]   pick   [N];
  logic [N-1:0]   ns_col [N];
  logic [N-1:0]   sp_col [N];
  logic [N-1:0]   win    [N];
  logic [N*N-1:0] gnt_n;
  logic [N-1:0]   used_n;
  logic [CW-1:0]  waste_n;

  for (genvar i = 0; i < N; i++) begin : g_in
    ssa_in_pick #(.N(N)) u_pick (.req(req_i[i*N +: N]), .pick(pick[i]));
  end

  always_comb begin
    for (int o = 0; o < N; o++) begin
      for (int i = 0; i < N; i++) begin
        ns_col[o][i] = pick[i][o] & ~spec_i[i];
        sp_col[o][i] = pick[i][o] &  spec_i[i];
      end
    end
  end

  for (genvar o = 0; o < N; o++) begin : g_out
    ssa_out_stage #(.N(N)) u_out (
      .clk(clk), .rst(rst),
      .ns_req(ns_col[o]), .sp_req(sp_col[o]),
      .va_ok(va_ok_i), .win(win[o])
    );
  end

  always_comb begin
    gnt_n   = '0;
    used_n  = '0;
    waste_n = '0;
    for (int i = 0; i < N; i++) begin
      for (int o = 0; o < N; o++) begin
        if (win[o][i]) begin
          gnt_n[i*N + o] = 1'b1;
          if (!spec_i[i] || va_ok_i[i]) used_n[i] = 1'b1;
          else waste_n = waste_n + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_o       <= '0;
      used_o      <= '0;
      waste_cnt_o <= '0;
    end else begin
      gnt_o       <= gnt_n;
      used_o      <= used_n;
      waste_cnt_o <= waste_n;
    end
  end
endmodule

// File: rtl/ssa_checker.sv
module ssa_checker #(
  parameter int N = 4,
  localparam int CW = $clog2(N + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic [N*N-1:0] req_i,
  input logic [N-1:0]   spec_i,
  input logic [N*N-1:0] gnt_o,
  input logic [N-1:0]   used_o,
  input logic [CW-1:0]  waste_cnt_o
);
  logic [N-1:0] col [N];
  logic [N-1:0] wasted;

  always_comb begin
    for (int o = 0; o < N; o++)
      for (int i = 0; i < N; i++)
        col[o][i] = gnt_o[i*N + o];
    for (int i = 0; i < N; i++)
      wasted[i] = (|gnt_o[i*N +: N]) && !used_o[i];
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(gnt_o[i*N +: N])); // R2
    AST_GNT_HAD_REQ: assert property (@(posedge clk) disable iff (rst)
      (gnt_o[i*N +: N] & ~$past(req_i[i*N +: N])) == '0); // R10
    AST_NS_ALWAYS_USED: assert property (@(posedge clk) disable iff (rst)
      ((|gnt_o[i*N +: N]) && !$past(spec_i[i])) |-> used_o[i]); // R9
    AST_USED_HAS_GNT: assert property (@(posedge clk) disable iff (rst)
      used_o[i] |-> (|gnt_o[i*N +: N])); // R6
  end

  for (genvar o = 0; o < N; o++) begin : g_col
    AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(col[o])); // R3
  end

  AST_WASTE_COUNT: assert property (@(posedge clk) disable iff (rst)
    int'(waste_cnt_o) == $countones(wasted)); // R7
endmodule

bind spec_sw_alloc ssa_checker #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .req_i(req_i), .spec_i(spec_i),
  .gnt_o(gnt_o), .used_o(used_o), .waste_cnt_o(waste_cnt_o)
);

// File: tb/spec_sw_alloc_bench.sv
`timescale 1ns/1ps
module spec_sw_alloc_bench;
  localparam int N  = 4;
  localparam int CW = $clog2(N + 1);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N*N-1:0] req_i = '0;
  logic [N-1:0]   spec_i = '0;
  logic [N-1:0]   va_ok_i = '0;
  logic [N*N-1:0] gnt_o;
  logic [N-1:0]   used_o;
  logic [CW-1:0]  waste_cnt_o;

  int n_chk = 0;
  int n_bad = 0;
  int nsp [N];
  int ssp [N];
  logic [N*N-1:0] e_g;
  logic [N-1:0]   e_u;
  int             e_w;
  logic [31:0]    rs = 32'h1234_5678;

  always #5 clk = ~clk;

  spec_sw_alloc #(.N(N)) u_spec_sw_alloc (
    .clk(clk), .rst(rst), .req_i(req_i), .spec_i(spec_i), .va_ok_i(va_ok_i),
    .gnt_o(gnt_o), .used_o(used_o), .waste_cnt_o(waste_cnt_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference decision from the requirements, then pointer update.
  task automatic model();
    int pk [N];
    e_g = '0; e_u = '0; e_w = 0;
    for (int i = 0; i < N; i++) begin
      pk[i] = -1;
      for (int o = N-1; o >= 0; o--) if (req_i[i*N + o]) pk[i] = o;
    end
    for (int o = 0; o < N; o++) begin
      bool_blk: begin
        int w; bit nsany; w = -1; nsany = 0;
        for (int i = 0; i < N; i++) if (pk[i] == o && !spec_i[i]) nsany = 1;
        for (int k = 0; k < N; k++) begin
          int c;
          c = ((nsany ? nsp[o] : ssp[o]) + k) % N;
          if (w < 0 && pk[c] == o && (spec_i[c] == !nsany)) w = c;
        end
        if (w >= 0) begin
          e_g[w*N + o] = 1'b1;
          if (nsany) begin
            e_u[w] = 1'b1; nsp[o] = (w + 1) % N;
          end else if (va_ok_i[w]) begin
            e_u[w] = 1'b1; ssp[o] = (w + 1) % N;
          end else e_w++;
        end
      end
    end
  endtask

  task automatic apply(input logic [N*N-1:0] r, input logic [N-1:0] s,
                       input logic [N-1:0] v, input string tg, input string tu);
    @(negedge clk);
    req_i = r; spec_i = s; va_ok_i = v;
    model();
    @(negedge clk);
    check(tg, 32'(gnt_o), 32'(e_g));
    check(tu, 32'(used_o), 32'(e_u));
    check("R7 waste count", 32'(waste_cnt_o), 32'(e_w));
    req_i = '0; spec_i = '0; va_ok_i = '0;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13); y = y ^ (y >> 17); y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int o = 0; o < N; o++) begin nsp[o] = 0; ssp[o] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 gnt after reset", 32'(gnt_o), 0);
    check("R1 used after reset", 32'(used_o), 0);
    check("R1 waste after reset", 32'(waste_cnt_o), 0);
    // R10 idle
    apply('0, '0, '0, "R10 no request", "R10 no used");
    // R2 lowest requested output: input0 asks outputs 1 and 3
    apply(16'h000A, '0, '0, "R2 input picks one", "R9 ns used va low");
    check("R2 input0 to output1", 32'(gnt_o), 32'h0002);
    // R3 / R1 pointer: all ask output 2, nonspec
    apply(16'h4444, '0, '0, "R3 one winner from reset ptr", "R9 used");
    check("R1 pointer starts at input0", 32'(gnt_o), 32'h0004);
    apply(16'h4444, '0, '0, "R5 rotation", "R5 used");
    check("R5 next input wins", 32'(gnt_o), 32'h0040);
    // R4 input0 spec vs input3 nonspec on output 1
    apply(16'h2002, 4'b0001, 4'b0001, "R4 nonspec priority", "R4 used");
    check("R4 input3 wins", 32'(gnt_o), 32'h2000);
    // R6 spec waste: inputs1,2 spec on output0, va fails
    apply(16'h0110, 4'b0110, 4'b0000, "R6 spec grant", "R6 unused");
    check("R6 input1 wins", 32'(gnt_o), 32'h0010);
    apply(16'h0110, 4'b0110, 4'b0000, "R6 pointer held", "R6 unused again");
    check("R6 same winner", 32'(gnt_o), 32'h0010);
    apply(16'h0110, 4'b0110, 4'b0010, "R6 va now ok", "R6 used");
    apply(16'h0110, 4'b0110, 4'b0110, "R5 spec rotation", "R5 spec used");
    check("R5 input2 after used", 32'(gnt_o), 32'h0100);
    // R8 latency: outputs hold until edge
    @(negedge clk);
    req_i = 16'h0001; spec_i = '0; va_ok_i = '0;
    #1;
    check("R8 no change before edge", 32'(gnt_o), 0);
    model();
    @(negedge clk);
    check("R8 after edge", 32'(gnt_o), 32'(e_g));
    req_i = '0;
    // random sweep
    for (int n = 0; n < 3000; n++) begin
      logic [N*N-1:0] r;
      rs = nxt(rs); r = rs[15:0] & rs[31:16];
      if (n % 3 == 0) r = rs[15:0];
      rs = nxt(rs);
      apply(r, rs[3:0], rs[7:4], "R5 sweep grant", "R6 sweep used");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule